// File: doc/BRIEF.md
# Wrap-Safe Quadrant Position Comparator

This block orders a feedback position against a target value when both sit on a counter that wraps around. A plain signed or unsigned compare gives a wrong answer when the counter passes from all ones to zero, or from the largest positive value to the most negative one. This block avoids that by splitting the counter circle into four quarters, using the top two bits of the active width, and reading the order from which quarters the two operands occupy.

The active width `W` is fixed when the design is built and can be 32 to 64 bits. The ports are always 64 bits wide, and only bits `[W-1:0]` take part in the compare. A narrower feedback source should be left-justified by the logic that feeds it, so that its most significant bits land on the quadrant bits.

Each valid input produces a registered result one clock later. If the operands sit half a circle apart, the order cannot be known. The block then raises an indeterminate flag and keeps its previous ordering result.

Top module: `quad_cmp`

## Requirements
- R1: While `rst_n` is low, and until the first valid input after it rises, `gt_o`, `lt_o`, `eq_o` and `indet_o` are all 0.
- R2: The quadrant of an operand is its bit pair `[W-1:W-2]`. When both operands are in the same quadrant, bits `[W-3:0]` are compared as unsigned numbers. Exactly one of `gt_o`, `lt_o`, `eq_o` is then set, and `indet_o` is cleared.
- R3: When the position quadrant equals (value quadrant + 1) mod 4, `gt_o` is set and the other three outputs are cleared.
- R4: When the value quadrant equals (position quadrant + 1) mod 4, `lt_o` is set and the other three outputs are cleared.
- R5: When the two quadrants differ by 2, `indet_o` is set and `gt_o`, `lt_o`, `eq_o` keep their previous values.
- R6: Results appear on the clock edge after the one that samples `valid_i` high. While `valid_i` is low, all four outputs hold their values.
- R7: Input bits at positions `W` and above have no effect on any output.
- R8: A position of 1 is greater than a value of all ones in `W` bits. A position of 2^(W-1)-1 is less than a value of 2^(W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Qualifies `pos_i` and `val_i` for this cycle |
| pos_i | input | 64 | Feedback position; only bits `[W-1:0]` are used |
| val_i | input | 64 | Compare value; only bits `[W-1:0]` are used |
| gt_o | output | 1 | Position is ahead of the value |
| lt_o | output | 1 | Position is behind the value |
| eq_o | output | 1 | Position equals the value |
| indet_o | output | 1 | Last valid pair was half a circle apart |

## Verification
The bench is built with `W` = 48 and drives values that cross both wrap points. A comparator that fell back to an unsigned or signed compare would invert the result at zero or at the sign boundary.

It places operands in every pairing of quadrants. A design that decoded adjacency the wrong way round would swap greater and less. A design that cleared or updated the ordering bits on an opposite pair would fail to hold them.

The bench also loads garbage into the bits above the width, which exposes any slice taken from the wrong position. Cycles with `valid_i` low carry changing inputs, which catches a design that does not gate its output register.

// File: rtl/quad_cmp.sv
module quad_cmp #(
  parameter int W = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid_i,
  input  logic [63:0] pos_i,
  input  logic [63:0] val_i,
  output logic        gt_o,
  output logic        lt_o,
  output logic        eq_o,
  output logic        indet_o
);
  localparam int LW = W - 2;

  logic [1:0]    qp, qv, qd;
  logic [LW-1:0] lp, lv;
  logic          n_gt, n_lt, n_eq;

  assign qp = pos_i[W-1:W-2];
  assign qv = val_i[W-1:W-2];
  assign lp = pos_i[LW-1:0];
  assign lv = val_i[LW-1:0];
  assign qd = qp - qv;

  if (W < 64) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^{pos_i[63:W], val_i[63:W]};
  end

  always_comb begin
    n_gt = 1'b0;
    n_lt = 1'b0;
    n_eq = 1'b0;
    unique case (qd)
      2'd0: begin
        n_gt = lp > lv;
        n_lt = lp < lv;
        n_eq = lp == lv;
      end
      2'd1: n_gt = 1'b1;
      2'd3: n_lt = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gt_o    <= 1'b0;
      lt_o    <= 1'b0;
      eq_o    <= 1'b0;
      indet_o <= 1'b0;
    end else if (valid_i) begin
      indet_o <= qd == 2'd2;
      if (qd != 2'd2) begin
        gt_o <= n_gt;
        lt_o <= n_lt;
        eq_o <= n_eq;
      end
    end
  end
endmodule

// File: rtl/quad_cmp_chk.sv
module quad_cmp_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         valid_i,
  input logic [W-1:0] pos_i,
  input logic [W-1:0] val_i,
  input logic         gt_o,
  input logic         lt_o,
  input logic         eq_o,
  input logic         indet_o
);
  logic [1:0] qa, qb;
  assign qa = pos_i[W-1:W-2];
  assign qb = val_i[W-1:W-2];

  // R2
  same_quad_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && qa == qb |=> $countones({gt_o, lt_o, eq_o}) == 1 && !indet_o);

  // R2
  same_quad_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && pos_i == val_i |=> eq_o);

  // R3
  ahead_quad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && qa == qb + 2'd1 |=> gt_o && !lt_o && !eq_o && !indet_o);

  // R4
  behind_quad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && qb == qa + 2'd1 |=> lt_o && !gt_o && !eq_o && !indet_o);

  // R5
  opposite_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i && (qa ^ qb) == 2'b10 |=> indet_o && $stable({gt_o, lt_o, eq_o}));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable({gt_o, lt_o, eq_o, indet_o}));

  // R2
  never_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gt_o, lt_o, eq_o}));
endmodule

bind quad_cmp quad_cmp_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_i(valid_i),
  .pos_i(pos_i[W-1:0]), .val_i(val_i[W-1:0]),
  .gt_o(gt_o), .lt_o(lt_o), .eq_o(eq_o), .indet_o(indet_o)
);

// File: tb/sim_quad_cmp.sv
`timescale 1ns/1ps
module sim_quad_cmp;
  localparam int W = 48;
  localparam longint unsigned MASK = (64'd1 << W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, valid = 1'b0;
  logic [63:0] pos = '0, val = '0;
  logic gt, lt, eq, indet;
  always #4 clk = ~clk;

  quad_cmp #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .valid_i(valid), .pos_i(pos), .val_i(val),
    .gt_o(gt), .lt_o(lt), .eq_o(eq), .indet_o(indet)
  );

  int vecs = 0, bad = 0;
  logic e_gt = 0, e_lt = 0, e_eq = 0, e_in = 0;
  string e_tag = "R1";

  task automatic check();
    vecs++;
    if ({gt, lt, eq, indet} !== {e_gt, e_lt, e_eq, e_in}) begin
      bad++;
      $display("FAIL %s: gt/lt/eq/indet got %b expected %b", e_tag,
               {gt, lt, eq, indet}, {e_gt, e_lt, e_eq, e_in});
    end
  endtask

  task automatic model(input logic [63:0] p, input logic [63:0] q);
    longint unsigned pm = p & MASK, vm = q & MASK;
    longint unsigned lo = MASK >> 2;
    int a = int'(pm >> (W - 2));
    int b = int'(vm >> (W - 2));
    int rel = (a - b + 4) % 4;
    e_in = (rel == 2);
    case (rel)
      0: begin
        e_gt = (pm & lo) > (vm & lo);
        e_lt = (pm & lo) < (vm & lo);
        e_eq = (pm & lo) == (vm & lo);
        e_tag = "R2";
      end
      1: begin e_gt = 1; e_lt = 0; e_eq = 0; e_tag = "R3"; end
      3: begin e_gt = 0; e_lt = 1; e_eq = 0; e_tag = "R4"; end
      default: e_tag = "R5";
    endcase
  endtask

  task automatic apply(input logic v, input logic [63:0] p, input logic [63:0] q,
                       input string t = "");
    @(negedge clk);
    check();
    valid = v; pos = p; val = q;
    if (v) model(p, q);
    else e_tag = "R6";
    if (t != "") e_tag = t;
  endtask

  function automatic logic [63:0] at(input int quad, input longint unsigned low);
    return (64'(quad) << (W - 2)) | (low & (MASK >> 2));
  endfunction

  initial begin
    repeat (3) begin @(negedge clk); e_tag = "R1"; check(); end
    rst_n = 1'b1;
    apply(0, 64'h5, 64'h3, "R1");
    apply(0, 64'h5, 64'h3, "R1");
    apply(1, at(1, 100), at(1, 50));
    apply(1, at(1, 50), at(1, 100));
    apply(1, at(2, 7), at(2, 7));
    apply(1, at(1, 9), at(0, 900));
    apply(1, at(0, 9), at(3, 900));
    apply(1, at(0, 900), at(1, 9));
    apply(1, at(3, 900), at(0, 9));
    apply(1, at(2, 1), at(0, 1));
    apply(0, at(1, 1), at(0, 1));
    apply(0, at(3, 1), at(3, 2));
    apply(1, at(1, 5), at(3, 5));
    apply(1, 64'h1, MASK, "R8");
    apply(1, MASK >> 1, (MASK >> 1) + 1, "R8");
    apply(1, 64'hABCD_0000_0000_0042, 64'h1234_0000_0000_0042, "R7");
    apply(1, 64'hFFFF_4000_0000_0000, 64'h0000_0000_0000_0001, "R7");
    for (int i = 0; i < 400; i++)
      apply(($urandom % 4) != 0, {$urandom, $urandom}, {$urandom, $urandom});
    @(negedge clk);
    check();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog: got no finish expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule